// File: doc/BRIEF.md
# Tagged HDLC Receive Byte Queue

This block sits between an HDLC deframer and a host read port. The deframer hands over one byte at a time with a 2-bit tag that says where the byte stands in its frame (inside the frame, opening byte, closing byte with a good check sequence, or closing byte with a bad one). The queue holds up to 19 such bytes. The host always sees the byte at the head together with its tag, and a 2-bit code that summarises how full the queue is or whether bytes have been lost.

The host can request a receive reset through a self-clearing control bit. The reset empties the queue, clears the loss indication and closes the input until the deframer reports a flag. Reception is also closed after the chip reset, so the first byte accepted always follows a flag. Flag detection, zero-bit removal and check-sequence evaluation belong to the deframer and are not part of this block.

Top module: `hrq_rx_tagq`

## Requirements
- R1: The queue stores up to 19 bytes and returns them on `rd_data` in the order they were accepted.
- R2: Each byte keeps the tag it arrived with (00 mid-frame, 01 first byte, 10 last byte with good check, 11 last byte with bad check); `rd_tag` is the tag of the head entry and changes in the same clock edge that pops the head.
- R3: `occ_code` is 00 whenever the queue is empty and no loss is pending; empty wins over the low-fill code.
- R4: `occ_code` is 01 while 1 to 14 bytes are held and 11 while 15 to 19 bytes are held.
- R5: A byte offered while 19 bytes are held is dropped, the stored bytes are unchanged, and `occ_code` reads 10 from the next cycle on, whatever the fill, until a receive reset.
- R6: A cycle with `rx_rst_wr` high while `rx_rst_bit` is 0 sets `rx_rst_bit` at that edge; at the following edge the queue is emptied, the loss indication is cleared, `occ_code` becomes 00 and `rx_rst_bit` returns to 0.
- R7: After a receive reset, offered bytes are ignored until a cycle with `flag_seen` high; bytes are accepted from the cycle after that flag.
- R8: After `rst_n` low, the queue is empty, `rx_rst_bit` is 0 and input is closed until a flag, as in R7.
- R9: A push and a pop in the same cycle, with the queue neither empty nor full, leave the fill unchanged and advance the head.
- R10: While the queue is empty `rd_data` and `rd_tag` read 0, and a pop request has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Deframer offers a byte this cycle |
| in_data | input | 8 | Offered byte |
| in_tag | input | 2 | Frame position / check tag of the offered byte |
| flag_seen | input | 1 | Deframer detected a flag this cycle |
| rd_pop | input | 1 | Host consumes the head entry |
| rx_rst_wr | input | 1 | Host writes 1 to the receive reset bit |
| rd_data | output | 8 | Head byte, 0 when empty |
| rd_tag | output | 2 | Tag of the head byte, 0 when empty |
| occ_code | output | 2 | 00 empty, 01 up to 14, 10 loss, 11 15 or more |
| rx_rst_bit | output | 1 | Receive reset bit, self-clearing |

## Verification
The assertions watch on every cycle that the reset bit drops one cycle after it rises, that a receive reset leaves the queue empty and closed, that a closed input never raises the fill, that the loss code stays until a reset, that the fill never passes 19, that a balanced push and pop hold the fill and that an empty queue shows zero data and tag. The ordering of bytes, the exact codes at the 14/15 boundary, the byte dropped at a full queue and the reopening on a flag need the bench's scenarios, which compare the read port against expected values built from the requirements.

// File: rtl/hrq_pkg.sv
// Package: shared encodings for the tagged receive byte queue.
// Assumes: tag and occupancy codes are 2 bits wide and fixed by the host view.
package hrq_pkg;

    localparam int TAG_W = 2;

    // Frame position / integrity tag carried with each byte.
    typedef enum logic [TAG_W-1:0] {
        TAG_MID      = 2'b00,
        TAG_FIRST    = 2'b01,
        TAG_LAST_OK  = 2'b10,
        TAG_LAST_BAD = 2'b11
    } rx_tag_e;

    // Occupancy / loss code shown to the host.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'b00,
        OCC_LOW   = 2'b01,
        OCC_LOSS  = 2'b10,
        OCC_HIGH  = 2'b11
    } occ_e;

endpackage

// File: rtl/hrq_ctrl.sv
// Module: hrq_ctrl
// Holds the self-clearing receive reset bit and the input gate.
// The bit is set by a host write, and one cycle later it requests the
// clear of the queue and drops again. The gate closes on a clear or on
// chip reset and opens only on a flag from the deframer.
// Assumes: rx_rst_wr is a single-cycle write strobe carrying the value 1.
module hrq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_rst_wr,
    input  logic flag_seen,
    output logic rx_rst_bit,
    output logic clearing,
    output logic rx_en
);

    // Reset bit: set on a write, self-clears on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rst_bit <= 1'b0;
        end else if (rx_rst_bit) begin
            rx_rst_bit <= 1'b0;
        end else if (rx_rst_wr) begin
            rx_rst_bit <= 1'b1;
        end
    end

    // Input gate: closed by reset or clear, opened by a flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
        end else if (rx_rst_bit) begin
            rx_en <= 1'b0;
        end else if (flag_seen) begin
            rx_en <= 1'b1;
        end
    end

    // The clear is performed while the reset bit reads 1.
    always_comb clearing = rx_rst_bit;

endmodule

// File: rtl/hrq_store.sv
// Module: hrq_store
// Circular store of DEPTH byte/tag entries with fill counter.
// DEPTH need not be a power of two; pointers wrap explicitly.
// Assumes: push is only raised when not full, pop only when not empty;
// clear wins over push and pop.
module hrq_store
    import hrq_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TAG_W-1:0]  wtag,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [TAG_W-1:0]  ent_tag  [DEPTH];

    // Advance a pointer with wrap at the last entry.
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Per-entry storage: each entry loads when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_data[i] <= '0;
                ent_tag[i]  <= '0;
            end else if (push && !clear && (wr_ptr == PTR_W'(i))) begin
                ent_data[i] <= wdata;
                ent_tag[i]  <= wtag;
            end
        end
    end

    // Pointer and fill counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Head selection by read pointer.
    always_comb begin
        head_data = '0;
        head_tag  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_ptr == PTR_W'(k)) begin
                head_data = ent_data[k];
                head_tag  = ent_tag[k];
            end
        end
    end

    // Fill flags.
    always_comb begin
        full  = (count == FULL_CNT);
        empty = (count == '0);
    end

endmodule

// File: rtl/hrq_status.sv
// Module: hrq_status
// Sticky loss flag and encoding of the 2-bit occupancy code.
// Priority: loss, then empty, then the low/high fill split at HI_MARK.
// Assumes: drop pulses for one cycle per byte lost at a full queue.
module hrq_status
    import hrq_pkg::*;
#(
    parameter int DEPTH   = 19,
    parameter int HI_MARK = 15,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             drop,
    input  logic [CNT_W-1:0] count,
    output logic             loss,
    output logic [1:0]       occ_code
);

    localparam logic [CNT_W-1:0] HI_CNT = CNT_W'(HI_MARK);

    // Loss flag: set by a dropped byte, cleared only by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            loss <= 1'b0;
        end else if (drop) begin
            loss <= 1'b1;
        end
    end

    // Occupancy code encoder.
    always_comb begin
        occ_e code;
        if (loss)                 code = OCC_LOSS;
        else if (count == '0)     code = OCC_EMPTY;
        else if (count < HI_CNT)  code = OCC_LOW;
        else                      code = OCC_HIGH;
        occ_code = code;
    end

endmodule

// File: rtl/hrq_rx_tagq.sv
// Module: hrq_rx_tagq (top)
// Tagged HDLC receive byte queue: accepts tagged bytes from a deframer
// while the input gate is open, presents the head entry to the host,
// reports fill/loss and executes the host receive reset.
// Assumes: the deframer offers at most one byte per cycle.
module hrq_rx_tagq
    import hrq_pkg::*;
#(
    parameter int DEPTH   = 19,
    parameter int DATA_W  = 8,
    parameter int HI_MARK = 15,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              flag_seen,
    input  logic              rd_pop,
    input  logic              rx_rst_wr,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [1:0]        occ_code,
    output logic              rx_rst_bit
);

    logic              clearing;
    logic              rx_en;
    logic              live;
    logic              push_ok;
    logic              pop_ok;
    logic              drop;
    logic              full;
    logic              empty;
    logic              loss;
    logic [CNT_W-1:0]  fill;
    logic [DATA_W-1:0] head_data;
    logic [TAG_W-1:0]  head_tag;

    hrq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rst_wr  (rx_rst_wr),
        .flag_seen  (flag_seen),
        .rx_rst_bit (rx_rst_bit),
        .clearing   (clearing),
        .rx_en      (rx_en)
    );

    // Qualify deframer and host requests against gate, clear and fill.
    always_comb begin
        live    = rx_en && !clearing;
        push_ok = in_valid && live && !full;
        drop    = in_valid && live && full;
        pop_ok  = rd_pop && !empty && !clearing;
    end

    hrq_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clearing),
        .push      (push_ok),
        .pop       (pop_ok),
        .wdata     (in_data),
        .wtag      (in_tag),
        .head_data (head_data),
        .head_tag  (head_tag),
        .count     (fill),
        .full      (full),
        .empty     (empty)
    );

    hrq_status #(
        .DEPTH   (DEPTH),
        .HI_MARK (HI_MARK)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clearing),
        .drop     (drop),
        .count    (fill),
        .loss     (loss),
        .occ_code (occ_code)
    );

    // Read port: zero while nothing is held.
    always_comb begin
        rd_data = empty ? '0 : head_data;
        rd_tag  = empty ? '0 : head_tag;
    end

endmodule

// File: rtl/hrq_rx_tagq_chk.sv
// Module: hrq_rx_tagq_chk
// Protocol checker for hrq_rx_tagq, attached by bind below.
// Assumes: it observes the top ports and the internal gate, fill and loss.
module hrq_rx_tagq_chk #(
    parameter int DEPTH   = 19,
    parameter int DATA_W  = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        rd_tag,
    input logic [1:0]        occ_code,
    input logic              rx_rst_bit,
    input logic              rx_en,
    input logic              loss,
    input logic [CNT_W-1:0]  fill
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // R6: reset bit reads 1 for exactly one cycle.
    a_r6_bit_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_bit |=> !rx_rst_bit);

    // R6: after the clear cycle the code shows empty.
    a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_bit |=> (occ_code == 2'b00 && fill == '0));

    // R7: the clear closes the input gate.
    a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_bit |=> !rx_en);

    // R7: with the gate closed the fill never rises.
    a_r7_no_fill_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && in_valid) |=> (fill <= $past(fill)));

    // R5: loss code is sticky until a receive reset.
    a_r5_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_code == 2'b10 && !rx_rst_bit) |=> (occ_code == 2'b10));

    // R1: the fill never exceeds the depth.
    a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_CNT);

    // R9: balanced push and pop keep the fill.
    a_r9_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_pop && rx_en && !rx_rst_bit && fill != '0 && fill != FULL_CNT)
        |=> (fill == $past(fill)));

    // R10: empty queue shows zero on the read port.
    a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> (rd_data == '0 && rd_tag == 2'b00));

    // R3: empty and no loss gives the empty code.
    a_r3_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && !loss) |-> (occ_code == 2'b00));

endmodule

bind hrq_rx_tagq hrq_rx_tagq_chk #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rd_pop     (rd_pop),
    .rd_data    (rd_data),
    .rd_tag     (rd_tag),
    .occ_code   (occ_code),
    .rx_rst_bit (rx_rst_bit),
    .rx_en      (rx_en),
    .loss       (loss),
    .fill       (fill)
);

// File: tb/tb_hrq_rx_tagq.sv
module tb_hrq_rx_tagq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] in_tag = '0;
    logic       flag_seen = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rx_rst_wr = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;
    logic [1:0] occ_code;
    logic       rx_rst_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hrq_rx_tagq dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_tag(in_tag), .flag_seen(flag_seen), .rd_pop(rd_pop),
        .rx_rst_wr(rx_rst_wr), .rd_data(rd_data), .rd_tag(rd_tag),
        .occ_code(occ_code), .rx_rst_bit(rx_rst_bit)
    );

    // Vector: {valid, data[7:0], tag[1:0], pop, exp_occ[1:0], exp_data[7:0], exp_tag[1:0]}
    localparam int NVEC = 10;
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 8'hA1, 2'b01, 1'b0, 2'b01, 8'hA1, 2'b01},  // R2 first byte at head
        {1'b1, 8'h22, 2'b00, 1'b0, 2'b01, 8'hA1, 2'b01},
        {1'b1, 8'h33, 2'b10, 1'b0, 2'b01, 8'hA1, 2'b01},
        {1'b0, 8'h00, 2'b00, 1'b1, 2'b01, 8'h22, 2'b00},  // R2 tag follows pop
        {1'b1, 8'h44, 2'b01, 1'b1, 2'b01, 8'h33, 2'b10},  // R9 push+pop
        {1'b0, 8'h00, 2'b00, 1'b1, 2'b01, 8'h44, 2'b01},
        {1'b0, 8'h00, 2'b00, 1'b1, 2'b00, 8'h00, 2'b00},  // R3 empty
        {1'b0, 8'h00, 2'b00, 1'b1, 2'b00, 8'h00, 2'b00},  // R10 pop on empty
        {1'b1, 8'h55, 2'b11, 1'b0, 2'b01, 8'h55, 2'b11},  // R2 bad-check tag
        {1'b0, 8'h00, 2'b00, 1'b1, 2'b00, 8'h00, 2'b00}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, sample 1 ns after the rising edge.
    task automatic cyc(input logic v, input logic [7:0] d, input logic [1:0] t,
                       input logic p, input logic f, input logic rw);
        @(negedge clk);
        in_valid = v; in_data = d; in_tag = t; rd_pop = p;
        flag_seen = f; rx_rst_wr = rw;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R8: reset state
        check("R8 occ", occ_code, 2'b00);
        check("R8 rst bit", rx_rst_bit, 0);
        check("R8 rd_data", rd_data, 0);

        // R8: input closed until a flag
        cyc(1'b1, 8'h99, 2'b01, 1'b0, 1'b0, 1'b0);
        idle();
        check("R8 closed after reset", occ_code, 2'b00);
        cyc(1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0);

        // Vector walk: R2, R3, R9, R10
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] v;
            v = VEC[i];
            cyc(v[23], v[22:15], v[14:13], v[12], 1'b0, 1'b0);
            check($sformatf("R2 vec%0d occ", i), occ_code, v[11:10]);
            check($sformatf("R2 vec%0d data", i), rd_data, v[9:2]);
            check($sformatf("R2 vec%0d tag", i), rd_tag, v[1:0]);
        end

        // R4: fill boundaries
        for (int i = 0; i < 19; i++) begin
            cyc(1'b1, 8'h10 + 8'(i), (i == 0) ? 2'b01 : 2'b00, 1'b0, 1'b0, 1'b0);
            if (i == 13) check("R4 14 held", occ_code, 2'b01);
            if (i == 14) check("R4 15 held", occ_code, 2'b11);
        end
        check("R4 19 held", occ_code, 2'b11);

        // R5: byte at full is dropped, loss code sticks
        cyc(1'b1, 8'hEE, 2'b10, 1'b0, 1'b0, 1'b0);
        check("R5 loss code", occ_code, 2'b10);
        check("R5 head kept", rd_data, 8'h10);
        check("R2 head tag first", rd_tag, 2'b01);

        // R1: read back in order
        for (int i = 0; i < 19; i++) begin
            check($sformatf("R1 order %0d", i), rd_data, 8'h10 + 8'(i));
            cyc(1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b0);
        end
        check("R1 drained", rd_data, 0);
        check("R5 loss sticky when empty", occ_code, 2'b10);

        // R6: receive reset
        cyc(1'b1, 8'h61, 2'b01, 1'b0, 1'b0, 1'b1);
        check("R6 bit set", rx_rst_bit, 1);
        idle();
        check("R6 bit clears", rx_rst_bit, 0);
        check("R6 empty code", occ_code, 2'b00);

        // R7: ignored until flag
        cyc(1'b1, 8'h62, 2'b01, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 8'h63, 2'b00, 1'b0, 1'b1, 1'b0);
        check("R7 ignored before flag", occ_code, 2'b00);
        cyc(1'b1, 8'h64, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R7 accepted after flag", occ_code, 2'b01);
        check("R7 byte", rd_data, 8'h64);

        // R6: clear discards held bytes
        cyc(1'b1, 8'h65, 2'b10, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b1);
        idle();
        check("R6 clears content", rd_data, 0);
        check("R6 code after clear", occ_code, 2'b00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule